// File: doc/BRIEF.md
# Banked Two-Line Reconstruction Buffer

This block keeps the reconstructed pixels of the line above the one being decoded, for the back end of a block-based display-stream decoder. Prediction logic asks for a column and receives two horizontally adjacent pixels one clock later. At the same time the reconstruction stage writes the current line into the buffer.

Only two line memories exist. One takes the writes of the current line while the other, holding the previous line, serves reads. The two memories swap roles on every line-start pulse. Each line memory is split by column parity into an even bank and an odd bank. A read at any column therefore touches each bank exactly once, and a write never lands in the memory being read. There are no stalls and the read latency is fixed. On the first line of a frame there is no line above, so reads return a default pixel supplied on a port.

Top module: `recon_line_buf`

## Requirements
- R1: `rd_valid` is high exactly one cycle after a cycle with `rd_en` high and low one cycle after a cycle with `rd_en` low; the pixel outputs belong to that request.
- R2: A read at an even column c returns the previous line's pixel c on `rd_pix0` and pixel c+1 on `rd_pix1`.
- R3: A read at an odd column c returns the same column order as R2: pixel c (from the odd bank) on `rd_pix0` and pixel c+1 (from the even bank) on `rd_pix1`.
- R4: From a `frame_start` pulse until the next `line_start` pulse, both read outputs equal the value of `dflt_pix` sampled in the request cycle.
- R5: A read at the last column (LINE_W-1) returns the `dflt_pix` value on `rd_pix1`, because no column exists to its right.
- R6: Pixels written during one line are returned by reads during the following line. A write and a read to the same column in the same cycle both take effect, and the read returns the previous line's pixel.
- R7: A read issued in the same cycle as a `line_start` pulse is served with the line roles in force before the pulse.
- R8: A cycle with `wr_en` low stores nothing, whatever `wr_col` and `wr_pix` carry.
- R9: During reset `rd_valid` is low. After reset the buffer behaves as on the first line of a frame, so reads return `dflt_pix` until the first `line_start`.
- R10: When `frame_start` and `line_start` are high together, `frame_start` wins: the next line is treated as a first line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse: the line now starting is the first of a frame |
| line_start | input | 1 | Pulse: swap write and read line memories |
| dflt_pix | input | PIX_W | Pixel returned where no stored neighbour exists |
| wr_en | input | 1 | Write strobe for one reconstructed pixel |
| wr_col | input | COL_W | Column of the written pixel |
| wr_pix | input | PIX_W | Reconstructed pixel (NCOMP components of COMP_W bits) |
| rd_en | input | 1 | Read request |
| rd_col | input | COL_W | Left column of the requested pixel pair |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_pix0 | output | PIX_W | Pixel at the requested column |
| rd_pix1 | output | PIX_W | Pixel at the requested column + 1 |

## Verification
A write of the current line and a read of the line above can happen in the same cycle and at the same column. The bench does exactly this, writing and reading column c together across whole lines, and expects every read to return the earlier line's value. A second coincidence is a read in the same cycle as a line-start pulse. The bench issues reads on those pulse cycles and checks that they still see the pre-swap roles. Expected pairs go into a queue as the requests are issued and are compared in order as the valid responses appear.

// File: rtl/rlb_pkg.sv
`timescale 1ns/1ps
package rlb_pkg;

    // Identity of one of the two line memories.
    typedef enum logic {
        LINE_A = 1'b0,
        LINE_B = 1'b1
    } line_id_e;

    // Per-request context carried alongside the bank read by one cycle.
    typedef struct packed {
        logic     odd;    // request started on an odd column
        logic     first;  // no line above exists
        logic     tail;   // requested column is the last one
        line_id_e src;    // line memory holding the previous line
    } rd_ctx_t;

    function automatic line_id_e other_line(input line_id_e l);
        return (l == LINE_A) ? LINE_B : LINE_A;
    endfunction

endpackage

// File: rtl/rlb_role_ctrl.sv
`timescale 1ns/1ps
module rlb_role_ctrl
    import rlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_start,
    input  logic     line_start,
    output line_id_e wr_line,
    output logic     first_line
);

    line_id_e wr_line_q;
    logic     first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_line_q <= LINE_A;
            first_q   <= 1'b1;
        end else if (frame_start) begin
            wr_line_q <= LINE_A;
            first_q   <= 1'b1;
        end else if (line_start) begin
            wr_line_q <= other_line(wr_line_q);
            first_q   <= 1'b0;
        end
    end

    assign wr_line    = wr_line_q;
    assign first_line = first_q;

endmodule

// File: rtl/rlb_bank.sv
`timescale 1ns/1ps
module rlb_bank #(
    parameter int DEPTH = 1920,
    parameter int AW    = 11,
    parameter int PIX_W = 30
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [PIX_W-1:0] rdata
);

    logic [PIX_W-1:0] mem [DEPTH];
    logic [PIX_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re && (int'(raddr) < DEPTH)) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/rlb_rd_path.sv
`timescale 1ns/1ps
module rlb_rd_path
    import rlb_pkg::*;
#(
    parameter int LINE_W = 3840,
    parameter int COL_W  = 12,
    parameter int AW     = 11,
    parameter int PIX_W  = 30
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_en,
    input  logic [COL_W-1:0]           rd_col,
    input  logic                       first_line,
    input  line_id_e                   wr_line,
    input  logic [PIX_W-1:0]           dflt_pix,
    output logic [1:0][1:0]            bank_re,
    output logic [AW-1:0]              even_addr,
    output logic [AW-1:0]              odd_addr,
    input  logic [1:0][1:0][PIX_W-1:0] bank_data,
    output logic                       rd_valid,
    output logic [PIX_W-1:0]           rd_pix0,
    output logic [PIX_W-1:0]           rd_pix1
);

    rd_ctx_t          ctx_d, ctx_q;
    logic             valid_q;
    logic [PIX_W-1:0] dflt_q;
    logic [PIX_W-1:0] left_pix, right_pix;

    // Request side: split the column into bank addresses.
    always_comb begin
        ctx_d.odd   = rd_col[0];
        ctx_d.first = first_line;
        ctx_d.tail  = (rd_col == COL_W'(LINE_W - 1));
        ctx_d.src   = other_line(wr_line);
        odd_addr    = rd_col[COL_W-1:1];
        even_addr   = rd_col[COL_W-1:1] + AW'(rd_col[0]);
    end

    // Only the memory holding the previous line is read.
    for (genvar l = 0; l < 2; l++) begin : g_re_line
        for (genvar b = 0; b < 2; b++) begin : g_re_bank
            assign bank_re[l][b] = rd_en && (ctx_d.src == line_id_e'(l));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ctx_q   <= '0;
            dflt_q  <= '0;
        end else begin
            valid_q <= rd_en;
            if (rd_en) begin
                ctx_q  <= ctx_d;
                dflt_q <= dflt_pix;
            end
        end
    end

    // Response side: restore column order, substitute the default.
    always_comb begin
        if (ctx_q.odd) begin
            left_pix  = bank_data[ctx_q.src][1];
            right_pix = bank_data[ctx_q.src][0];
        end else begin
            left_pix  = bank_data[ctx_q.src][0];
            right_pix = bank_data[ctx_q.src][1];
        end
        rd_pix0 = ctx_q.first ? dflt_q : left_pix;
        rd_pix1 = (ctx_q.first || ctx_q.tail) ? dflt_q : right_pix;
    end

    assign rd_valid = valid_q;

endmodule

// File: rtl/recon_line_buf.sv
`timescale 1ns/1ps
module recon_line_buf
    import rlb_pkg::*;
#(
    parameter int  LINE_W = 3840,
    parameter int  COMP_W = 10,
    parameter int  NCOMP  = 3,
    localparam int PIX_W  = COMP_W * NCOMP,
    localparam int COL_W  = $clog2(LINE_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             line_start,
    input  logic [PIX_W-1:0] dflt_pix,
    input  logic             wr_en,
    input  logic [COL_W-1:0] wr_col,
    input  logic [PIX_W-1:0] wr_pix,
    input  logic             rd_en,
    input  logic [COL_W-1:0] rd_col,
    output logic             rd_valid,
    output logic [PIX_W-1:0] rd_pix0,
    output logic [PIX_W-1:0] rd_pix1
);

    localparam int AW    = COL_W - 1;
    localparam int DEPTH = (LINE_W + 1) / 2;

    line_id_e                   wr_line;
    logic                       first_line;
    logic [1:0][1:0]            bank_re;
    logic [AW-1:0]              even_addr, odd_addr;
    logic [1:0][1:0][PIX_W-1:0] bank_data;

    rlb_role_ctrl u_role (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .line_start (line_start),
        .wr_line    (wr_line),
        .first_line (first_line)
    );

    rlb_rd_path #(
        .LINE_W(LINE_W),
        .COL_W (COL_W),
        .AW    (AW),
        .PIX_W (PIX_W)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_col    (rd_col),
        .first_line(first_line),
        .wr_line   (wr_line),
        .dflt_pix  (dflt_pix),
        .bank_re   (bank_re),
        .even_addr (even_addr),
        .odd_addr  (odd_addr),
        .bank_data (bank_data),
        .rd_valid  (rd_valid),
        .rd_pix0   (rd_pix0),
        .rd_pix1   (rd_pix1)
    );

    // Two line memories, each split into even (b=0) and odd (b=1) banks.
    for (genvar l = 0; l < 2; l++) begin : g_line
        for (genvar b = 0; b < 2; b++) begin : g_bank
            logic bank_we;
            assign bank_we = wr_en && (wr_line == line_id_e'(l)) && (wr_col[0] == 1'(b));
            rlb_bank #(
                .DEPTH(DEPTH),
                .AW   (AW),
                .PIX_W(PIX_W)
            ) u_bank (
                .clk  (clk),
                .we   (bank_we),
                .waddr(wr_col[COL_W-1:1]),
                .wdata(wr_pix),
                .re   (bank_re[l][b]),
                .raddr((b == 1) ? odd_addr : even_addr),
                .rdata(bank_data[l][b])
            );
        end
    end

endmodule

// File: rtl/rlb_checker.sv
`timescale 1ns/1ps
module rlb_checker
    import rlb_pkg::*;
#(
    parameter int  LINE_W = 3840,
    parameter int  PIX_W  = 30,
    localparam int COL_W  = $clog2(LINE_W)
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_start,
    input logic             line_start,
    input logic             rd_en,
    input logic [COL_W-1:0] rd_col,
    input logic [PIX_W-1:0] dflt_pix,
    input logic             rd_valid,
    input logic [PIX_W-1:0] rd_pix0,
    input logic [PIX_W-1:0] rd_pix1,
    input line_id_e         wr_line,
    input logic             first_line
);

    p_valid_hi_r1: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    p_valid_lo_r1: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    p_first_default_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && first_line) |=> (rd_pix0 == $past(dflt_pix)) && (rd_pix1 == $past(dflt_pix)));

    p_tail_default_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_col == COL_W'(LINE_W - 1)) |=> (rd_pix1 == $past(dflt_pix)));

    p_role_swap_r6: assert property (@(posedge clk) disable iff (rst)
        (line_start && !frame_start) |=> (wr_line != $past(wr_line)) && !first_line);

    p_frame_wins_r10: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> first_line && (wr_line == LINE_A));

    p_reset_idle_r9: assert property (@(posedge clk)
        rst |=> !rd_valid && first_line);

endmodule

bind recon_line_buf rlb_checker #(
    .LINE_W(LINE_W),
    .PIX_W (PIX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .line_start (line_start),
    .rd_en      (rd_en),
    .rd_col     (rd_col),
    .dflt_pix   (dflt_pix),
    .rd_valid   (rd_valid),
    .rd_pix0    (rd_pix0),
    .rd_pix1    (rd_pix1),
    .wr_line    (wr_line),
    .first_line (first_line)
);

// File: tb/sim_recon_line_buf.sv
`timescale 1ns/1ps
module sim_recon_line_buf;

    localparam int LW = 3840;
    localparam int CW = $clog2(LW);
    localparam int PW = 30;

    typedef struct {
        logic [PW-1:0] e0;
        logic [PW-1:0] e1;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_start = 1'b0, line_start = 1'b0;
    logic [PW-1:0] dflt_pix = 30'h0ABC_DEF;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [CW-1:0] wr_col = '0, rd_col = '0;
    logic [PW-1:0] wr_pix = '0;
    logic          rd_valid;
    logic [PW-1:0] rd_pix0, rd_pix1;

    int   checks = 0;
    int   errors = 0;
    bit   drv_re = 1'b0;
    bit   done   = 1'b0;
    exp_t sb[$];

    // Reference: previous line and line under construction.
    logic [PW-1:0] ref_prev [LW];
    logic [PW-1:0] ref_cur  [LW];
    bit            ref_first = 1'b1;

    always #2.5 clk = ~clk;

    recon_line_buf u0 (
        .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
        .dflt_pix(dflt_pix), .wr_en(wr_en), .wr_col(wr_col), .wr_pix(wr_pix),
        .rd_en(rd_en), .rd_col(rd_col), .rd_valid(rd_valid),
        .rd_pix0(rd_pix0), .rd_pix1(rd_pix1)
    );

    function automatic logic [PW-1:0] pat(input int ln, input int c);
        return PW'(ln * 1000003 + c * 37 + 5);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [PW-1:0] got, input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected pair pushed for reads.
    task automatic cyc(input bit fs, input bit ls, input bit we, input int wc,
                       input logic [PW-1:0] wp, input bit re, input int rc, input string tag);
        exp_t e;
        @(negedge clk);
        frame_start = fs; line_start = ls;
        wr_en = we; wr_col = CW'(wc); wr_pix = wp;
        rd_en = re; rd_col = CW'(rc);
        drv_re = re;
        if (re) begin
            e.e0  = ref_first ? dflt_pix : ref_prev[rc];
            e.e1  = (ref_first || rc == LW - 1) ? dflt_pix : ref_prev[rc + 1];
            e.tag = tag;
            sb.push_back(e);
        end
        if (we) ref_cur[wc] = wp;
        if (fs) ref_first = 1'b1;
        else if (ls) begin
            for (int i = 0; i < LW; i++) ref_prev[i] = ref_cur[i];
            ref_first = 1'b0;
        end
    endtask

    // Monitor: sampled 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst) begin
                check(rd_valid == 1'b0, "R9 valid low in reset", PW'(rd_valid), '0);
            end else begin
                check(rd_valid == drv_re, "R1 valid timing", PW'(rd_valid), PW'(drv_re));
                if (rd_valid && sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rd_pix0 == e.e0, {e.tag, " pix0"}, rd_pix0, e.e0);
                    check(rd_pix1 == e.e1, {e.tag, " pix1"}, rd_pix1, e.e1);
                end else if (rd_valid) begin
                    check(1'b0, "R1 unexpected response", PW'(rd_valid), '0);
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LW; i++) begin ref_prev[i] = '0; ref_cur[i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R9: after reset, first-line behaviour without a frame pulse
        cyc(0, 0, 0, 0, '0, 1, 5, "R9 default after reset");
        cyc(1, 0, 0, 0, '0, 1, 7, "R4 read on frame pulse");
        // Line 0 of frame: write everything, reads give default (R4)
        for (int c = 0; c < LW; c++) cyc(0, 0, 1, c, pat(0, c), 1, c, "R4 first line default");
        // R7: read on the line_start cycle still sees first-line roles
        cyc(0, 1, 0, 0, '0, 1, 10, "R7 read at swap");
        // Line 1: same-column write and read each cycle (R6, R2, R3, R5)
        for (int c = 0; c < LW; c++) begin
            string t;
            t = (c == LW - 1) ? "R5 last column" : ((c % 2) ? "R3 odd start" : "R2 even start");
            cyc(0, 0, 1, c, pat(1, c), 1, c, {t, " R6 collide"});
        end
        // R8: disabled write with junk data at a written column
        cyc(0, 0, 0, 100, 30'h3FFF_FFFF, 1, 101, "R8 idle write cycle");
        cyc(0, 0, 0, 0, '0, 0, 0, "R1 idle");
        // R7: read at swap cycle, odd column, still previous roles
        cyc(0, 1, 0, 0, '0, 1, 33, "R7 read at swap odd");
        // Line 2: strided reads, including tail and its neighbour
        for (int c = 0; c < LW; c++) cyc(0, 0, 1, c, pat(2, c), (c % 3) == 0, c, "R2 R3 strided");
        cyc(0, 0, 0, 0, '0, 1, 100, "R8 column untouched");
        cyc(0, 0, 0, 0, '0, 1, LW - 1, "R5 tail");
        cyc(0, 0, 0, 0, '0, 1, LW - 2, "R2 near tail");
        cyc(0, 0, 0, 0, '0, 1, 0, "R2 column zero");
        // R10: frame and line pulses together; new default value
        dflt_pix = 30'h1234_567;
        cyc(1, 1, 0, 0, '0, 1, 3, "R10 read at joint pulse");
        for (int c = 0; c < 16; c++) cyc(0, 0, 1, c, pat(3, c), 1, c, "R10 R4 new frame default");
        cyc(0, 1, 0, 0, '0, 0, 0, "R6 swap");
        for (int c = 0; c < 14; c++) cyc(0, 0, 0, 0, '0, 1, c, "R6 next line sees frame line");
        cyc(0, 0, 0, 0, '0, 0, 0, "R1 idle");
        cyc(0, 0, 0, 0, '0, 0, 0, "R1 idle");
        @(negedge clk);
        check(sb.size() == 0, "R1 all responses seen", PW'(sb.size()), '0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule